// File: doc/BRIEF.md
# Parallel Bit Deposit Unit

This unit scatters the low-order bits of a source word into the bit positions picked out by a mask word. Walking the mask from its least significant bit upward, the k-th set mask bit (counting from zero) receives source bit k. Every position whose mask bit is clear comes out as zero. Source bits beyond the number of set mask bits never reach the result.

The operation runs at 32 or 64 bits. When the long-mode flag is high, the width select picks between the two sizes. When the flag is low, the operation is always 32 bits and the width select has no effect. A nonzero vector-length field makes the request illegal. Such a request raises an undefined-instruction fault and produces no result. The output is registered, so each accepted request answers exactly one clock later. The unit has no status-flag outputs.

Top module: `bit_scatter_unit`

## Requirements
- R1: For an accepted request, result bit m equals source bit k when mask bit m is set, where k is the number of set mask bits below position m.
- R2: Every result bit whose mask bit is clear is zero.
- R3: Source bits at or above index popcount(mask) do not change the result.
- R4: With `long_mode`=1, `wide_sel`=1 gives a 64-bit operation and `wide_sel`=0 gives a 32-bit operation.
- R5: With `long_mode`=0 the operation is 32 bits whatever the value of `wide_sel`.
- R6: A request with `vec_len` other than 0 drives `ud_fault` high for one cycle, one clock after the request. In that cycle `res_valid` stays low and `res_word` is zero.
- R7: In a 32-bit operation, bits 63..32 of the source and the mask are ignored, and bits 63..32 of the result are zero.
- R8: `res_valid` goes high exactly one clock after a legal request (`in_valid`=1, `vec_len`=0). In every other cycle, `res_valid`, `ud_fault` and `res_word` are low.
- R9: Synchronous active-high `rst` clears `res_word`, `res_valid` and `ud_fault` at the next clock edge.
- R10: Corner cases: an all-zero mask gives zero; an all-ones mask returns the source truncated to the operation width; a 64-bit mask with only bit 63 set places source bit 0 at bit 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| src_word | input | 64 | Source operand whose low bits are scattered |
| mask_word | input | 64 | Mask selecting the destination positions |
| wide_sel | input | 1 | Width select; 1 = 64-bit, honoured only in long mode |
| long_mode | input | 1 | High when executing in 64-bit mode |
| vec_len | input | 2 | Vector-length field; any nonzero value is illegal |
| res_word | output | 64 | Registered result |
| res_valid | output | 1 | Result strobe, one clock after a legal request |
| ud_fault | output | 1 | Undefined-instruction fault, one clock after an illegal request |

## Verification
The per-position prefix counts are the only internal state worth checking. A wrong count shifts which source bit lands at a set mask position. The error shows in `res_word` in the very next cycle, but only for masks that have a set bit above the faulty position, so the bench sweeps every low-byte mask and uses pseudo-random 64-bit masks. A wrong width or fault decode shows in that same cycle as nonzero upper result bits, a missing strobe, or a fault raised alongside a valid result.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
    localparam int unsigned DATA_W = 64;
    localparam int unsigned HALF_W = 32;
    localparam int unsigned VL_W   = 2;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              valid;
        logic              fault;
    } bsu_out_t;
endpackage

// File: rtl/bsu_ctrl.sv
// Decodes the control fields into an operation width, an accept and a fault.
module bsu_ctrl #(
    parameter int unsigned VL_W = bsu_pkg::VL_W
) (
    input  logic            in_valid,
    input  logic            long_mode,
    input  logic            wide_sel,
    input  logic [VL_W-1:0] vec_len,
    output logic            op_wide,
    output logic            accept,
    output logic            fault
);
    logic illegal;

    always_comb begin
        illegal = (vec_len != '0);
        // Width select only matters in long mode
        op_wide = long_mode & wide_sel;
        accept  = in_valid & ~illegal;
        fault   = in_valid &  illegal;
    end
endmodule

// File: rtl/bsu_prefix_count.sv
// For each position m: count of set mask bits strictly below m.
module bsu_prefix_count #(
    parameter int unsigned DATA_W = bsu_pkg::DATA_W,
    localparam int unsigned IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] mask,
    output logic [IDX_W-1:0]  idx [DATA_W]
);
    assign idx[0] = '0;

    for (genvar m = 1; m < DATA_W; m++) begin : g_pfx
        assign idx[m] = idx[m-1] + IDX_W'(mask[m-1]);
    end
endmodule

// File: rtl/bsu_scatter.sv
// Mask-driven scatter of low source bits, width-gated.
module bsu_scatter #(
    parameter int unsigned DATA_W = bsu_pkg::DATA_W,
    parameter int unsigned HALF_W = bsu_pkg::HALF_W,
    localparam int unsigned IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] mask,
    input  logic              op_wide,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] src_eff;
    logic [DATA_W-1:0] mask_eff;
    logic [IDX_W-1:0]  idx [DATA_W];

    always_comb begin
        src_eff  = src;
        mask_eff = mask;
        if (!op_wide) begin
            src_eff[DATA_W-1:HALF_W]  = '0;
            mask_eff[DATA_W-1:HALF_W] = '0;
        end
    end

    bsu_prefix_count #(.DATA_W(DATA_W)) u_pfx (
        .mask (mask_eff),
        .idx  (idx)
    );

    for (genvar m = 0; m < DATA_W; m++) begin : g_sel
        assign result[m] = mask_eff[m] & src_eff[idx[m]];
    end
endmodule

// File: rtl/bit_scatter_unit.sv
module bit_scatter_unit
    import bsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_word,
    input  logic [DATA_W-1:0] mask_word,
    input  logic              wide_sel,
    input  logic              long_mode,
    input  logic [VL_W-1:0]   vec_len,
    output logic [DATA_W-1:0] res_word,
    output logic              res_valid,
    output logic              ud_fault
);
    logic              op_wide;
    logic              accept;
    logic              fault;
    logic [DATA_W-1:0] scat;
    bsu_out_t          out_d, out_q;

    bsu_ctrl #(.VL_W(VL_W)) u_ctrl (
        .in_valid  (in_valid),
        .long_mode (long_mode),
        .wide_sel  (wide_sel),
        .vec_len   (vec_len),
        .op_wide   (op_wide),
        .accept    (accept),
        .fault     (fault)
    );

    bsu_scatter #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_scat (
        .src     (src_word),
        .mask    (mask_word),
        .op_wide (op_wide),
        .result  (scat)
    );

    always_comb begin
        out_d       = '0;
        out_d.valid = accept;
        out_d.fault = fault;
        if (accept) begin
            out_d.res = scat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_word  = out_q.res;
    assign res_valid = out_q.valid;
    assign ud_fault  = out_q.fault;
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker
    import bsu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] mask_word,
    input logic              wide_sel,
    input logic              long_mode,
    input logic [VL_W-1:0]   vec_len,
    input logic [DATA_W-1:0] res_word,
    input logic              res_valid,
    input logic              ud_fault
);
    AST_OFF_MASK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vec_len == '0) |=> ((res_word & ~$past(mask_word)) == '0)); // R2

    AST_POP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vec_len == '0) |=> ($countones(res_word) <= $countones($past(mask_word)))); // R1

    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !(long_mode && wide_sel)) |=> (res_word[DATA_W-1:HALF_W] == '0)); // R7

    AST_LEGAL_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vec_len == '0) |=> (res_valid && !ud_fault)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!res_valid && !ud_fault && res_word == '0)); // R8

    AST_FAULT_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vec_len != '0) |=> (ud_fault && !res_valid && res_word == '0)); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!res_valid && !ud_fault && res_word == '0)); // R9
endmodule

bind bit_scatter_unit bsu_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mask_word (mask_word),
    .wide_sel  (wide_sel),
    .long_mode (long_mode),
    .vec_len   (vec_len),
    .res_word  (res_word),
    .res_valid (res_valid),
    .ud_fault  (ud_fault)
);

// File: tb/bit_scatter_unit_test.sv
`timescale 1ns/1ps
module bit_scatter_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] src_word, mask_word;
    logic        wide_sel, long_mode;
    logic [1:0]  vec_len;
    logic [63:0] res_word;
    logic        res_valid, ud_fault;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [63:0] lcg = 64'h1234_5678_9abc_def1;

    always #10 clk = ~clk;

    bit_scatter_unit uut (
        .clk (clk), .rst (rst), .in_valid (in_valid),
        .src_word (src_word), .mask_word (mask_word),
        .wide_sel (wide_sel), .long_mode (long_mode), .vec_len (vec_len),
        .res_word (res_word), .res_valid (res_valid), .ud_fault (ud_fault)
    );

    function automatic logic [63:0] ref_dep(logic [63:0] s, logic [63:0] m, int nb);
        logic [63:0] r = '0;
        int k = 0;
        for (int p = 0; p < nb; p++) begin
            if (m[p]) begin
                r[p] = s[k];
                k++;
            end
        end
        return r;
    endfunction

    function automatic logic [63:0] next_rand();
        lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
        return lcg ^ (lcg >> 29);
    endfunction

    task automatic check(string tag, logic [63:0] exp_r, logic exp_v, logic exp_f);
        n_checks++;
        if (res_word !== exp_r || res_valid !== exp_v || ud_fault !== exp_f) begin
            n_fails++;
            $display("FAIL %s: got res=%h v=%b f=%b, expected res=%h v=%b f=%b",
                     tag, res_word, res_valid, ud_fault, exp_r, exp_v, exp_f);
        end
    endtask

    // Drive at a falling edge, check at the next falling edge.
    task automatic op(string tag, logic v, logic lm, logic w, logic [1:0] vl,
                      logic [63:0] s, logic [63:0] m);
        int nb;
        logic [63:0] er;
        in_valid = v; long_mode = lm; wide_sel = w; vec_len = vl;
        src_word = s; mask_word = m;
        nb = (lm && w) ? 64 : 32;
        er = (v && vl == 2'd0) ? ref_dep(s, m, nb) : 64'd0;
        @(negedge clk);
        check(tag, er, v && vl == 2'd0, v && vl != 2'd0);
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] s, m, r1;
        rst = 1'b1; in_valid = 1'b1; long_mode = 1'b1; wide_sel = 1'b1;
        vec_len = 2'd0; src_word = '1; mask_word = '1;
        @(negedge clk); @(negedge clk);
        check("R9 reset", 64'd0, 1'b0, 1'b0);
        rst = 1'b0;

        // R1 R2 R4: sweep every low-byte mask against several sources (64-bit)
        for (int mi = 0; mi < 256; mi++)
            for (int si = 0; si < 16; si++)
                op("R1", 1'b1, 1'b1, 1'b1, 2'd0,
                   {48'hA5A5_F00F_3C3C, 12'h000, si[3:0]} ^ {56'd0, si[3:0], 4'b1010},
                   {56'h0, mi[7:0]});

        // R1 R4 R7: random 64-bit and 32-bit in long mode
        for (int i = 0; i < 2000; i++) begin
            s = next_rand(); m = next_rand();
            op("R4", 1'b1, 1'b1, i[0], 2'd0, s, m);
        end
        // R5: outside long mode W ignored
        for (int i = 0; i < 1000; i++) begin
            s = next_rand(); m = next_rand();
            op("R5", 1'b1, 1'b0, i[0], 2'd0, s, m);
        end

        // R3: flipping source bits above popcount(mask) changes nothing
        for (int i = 0; i < 200; i++) begin
            m = next_rand() & next_rand();
            s = next_rand();
            op("R3", 1'b1, 1'b1, 1'b1, 2'd0, s, m);
            r1 = res_word;
            s = s ^ ~((64'd1 << $countones(m)) - 64'd1);
            if ($countones(m) == 64) s = s ^ '1;
            op("R3", 1'b1, 1'b1, 1'b1, 2'd0, s, m);
            n_checks++;
            if (res_word !== r1) begin
                n_fails++;
                $display("FAIL R3: got %h, expected %h", res_word, r1);
            end
        end

        // R7: upper halves ignored in 32-bit mode
        op("R7", 1'b1, 1'b1, 1'b0, 2'd0, 64'hFFFF_FFFF_0000_00F3, 64'hFFFF_FFFF_0000_0F0F);
        check("R7", 64'h0000_0000_0000_0F03, 1'b1, 1'b0);

        // R6: illegal vector length, all nonzero codes
        for (int vl = 1; vl < 4; vl++)
            op("R6", 1'b1, 1'b1, 1'b1, vl[1:0], '1, '1);
        op("R6 recover", 1'b1, 1'b1, 1'b1, 2'd0, 64'h3, 64'h5);
        check("R6 recover", 64'h5, 1'b1, 1'b0);

        // R8: idle cycles and back-to-back
        op("R8 idle", 1'b0, 1'b1, 1'b1, 2'd0, '1, '1);
        op("R8 idle", 1'b0, 1'b1, 1'b1, 2'd2, '1, '1);

        // R10 corner cases
        op("R10 zero mask", 1'b1, 1'b1, 1'b1, 2'd0, '1, 64'd0);
        op("R10 ones mask", 1'b1, 1'b1, 1'b1, 2'd0, 64'hDEAD_BEEF_0123_4567, '1);
        check("R10 ones mask", 64'hDEAD_BEEF_0123_4567, 1'b1, 1'b0);
        op("R10 ones narrow", 1'b1, 1'b0, 1'b1, 2'd0, 64'hDEAD_BEEF_0123_4567, '1);
        check("R10 ones narrow", 64'h0000_0000_0123_4567, 1'b1, 1'b0);
        op("R10 bit63", 1'b1, 1'b1, 1'b1, 2'd0, 64'h1, 64'h8000_0000_0000_0000);
        check("R10 bit63", 64'h8000_0000_0000_0000, 1'b1, 1'b0);
        op("R10 bit63 narrow", 1'b1, 1'b1, 1'b0, 2'd0, 64'h1, 64'h8000_0000_0000_0000);
        check("R10 bit63 narrow", 64'd0, 1'b1, 1'b0);

        // R9: reset mid-stream
        in_valid = 1'b1; vec_len = 2'd0; src_word = '1; mask_word = '1; rst = 1'b1;
        @(negedge clk);
        check("R9 mid reset", 64'd0, 1'b0, 1'b0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule